// File: doc/BRIEF.md
# Global Tick Timer with Periodic Comparator

This block keeps a 64-bit up-counter that advances by one on every cycle where the tick input is high and the run bit is set. Software reaches the counter, a 64-bit compare value, a 32-bit step, a control word, an interrupt enable and an interrupt status through a plain 32-bit register bus. The bus has an address, a write enable, write data, and read data that is a combinational decode of the address. The bus has no valid/ready pair, so it applies no back-pressure: every write is accepted on the clock edge where the write enable is high.

When the comparator is enabled and the counter advances out of a value equal to the compare value, the block records a match in a sticky status bit. The level interrupt output is that status bit gated by the enable bit. If auto-increment is on, every match adds the step to the compare value, which makes the interrupt recur every step ticks. Each write to the control, compare, step or counter registers raises a write-acknowledge flag one cycle after the write takes effect. Software polls this flag and clears it by writing a one to it.

Top module: `gtick_timer`

## Requirements
- R1: Address 0x100 holds bits 31:0 of the counter and address 0x104 holds bits 63:32. A write to one half replaces only that half, and a counter write takes priority over counting in the same cycle.
- R2: Control bit 8 (address 0x240) is the run bit. While it is set, the counter rises by one on each cycle where tick is high. It holds otherwise, and it wraps from all ones to zero.
- R3: When control bit 0 (comparator enable) is set, a cycle where the counter advances while equal to the compare value (low half 0x200, high half 0x204) is a match. A match sets bit 0 of the status register at 0x244. With bit 0 clear, the counter passing the compare value does not set the status bit.
- R4: Status bit 0 stays set until software writes 1 to it. If a match falls in the same cycle as that clearing write, the bit stays set.
- R5: The irq output equals status bit 0 AND bit 0 of the enable register at 0x248. The status bit is set by a match whether or not irq is enabled.
- R6: When control bit 1 (auto-increment) is set, each match adds the step at 0x208 to the 64-bit compare value. A software write to the compare value in the match cycle wins over the addition.
- R7: The acknowledge register at 0x24C sets bit 16 after a control write, and sets bits 0, 1 and 2 after writes to the compare low half, the compare high half and the step. Each bit appears one cycle after the write edge and is cleared by writing 1 to it.
- R8: The acknowledge register at 0x110 sets bit 0 after a counter low write and bit 1 after a counter high write, with the same one-cycle delay and write-1-to-clear rule.
- R9: After reset, the counter, compare value, step, control, enable, status, both acknowledge registers and irq are all zero.
- R10: Reads of any address not listed above return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable pulse, one count per high cycle |
| addr | input | 12 | Register byte address |
| wr_en | input | 1 | Write strobe, applied at the clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can collide in one cycle. A match can set the status bit while software writes 1 to clear it, and the auto-increment can update the compare value while software writes it. The bench provokes both by holding tick high and counting edges, so that a write to the status register, and later a write to the compare low half, lands on exactly the edge where the counter leaves the compare value. It then reads back the status and the compare value. The status must still be set, and the compare value must be the written one rather than the incremented one.

// File: rtl/gtick_pkg.sv
package gtick_pkg;

  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_CNT_LO  = 12'h100;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 12'h104;
  localparam logic [ADDR_W-1:0] A_CNT_ACK = 12'h110;
  localparam logic [ADDR_W-1:0] A_CMP_LO  = 12'h200;
  localparam logic [ADDR_W-1:0] A_CMP_HI  = 12'h204;
  localparam logic [ADDR_W-1:0] A_STEP    = 12'h208;
  localparam logic [ADDR_W-1:0] A_CTRL    = 12'h240;
  localparam logic [ADDR_W-1:0] A_ISTAT   = 12'h244;
  localparam logic [ADDR_W-1:0] A_IEN     = 12'h248;
  localparam logic [ADDR_W-1:0] A_ACK     = 12'h24C;

  // control field positions
  localparam int B_CMP_EN = 0;
  localparam int B_AUTO   = 1;
  localparam int B_RUN    = 8;

  // global acknowledge: internal index -> register bit
  localparam int ACK_N     = 4;
  localparam int ACK_CMPLO = 0;
  localparam int ACK_CMPHI = 1;
  localparam int ACK_STEP  = 2;
  localparam int ACK_CTRL  = 3;
  localparam int B_ACK_CTRL = 16;

  localparam int CACK_N = 2;

  typedef struct packed {
    logic run;
    logic auto_inc;
    logic cmp_en;
  } ctrl_t;

endpackage

// File: rtl/gtick_counter.sv
module gtick_counter #(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  advance,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [HALF_W-1:0]     wdata,
  output logic [2*HALF_W-1:0]   count
);
  localparam int CW = 2 * HALF_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) count[HALF_W-1:0]  <= wdata;
      if (wr_hi) count[CW-1:HALF_W] <= wdata;
    end else if (advance) begin
      count <= count + CW'(1);
    end
  end

endmodule

// File: rtl/gtick_compare.sv
module gtick_compare #(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  advance,
  input  logic                  enable,
  input  logic                  auto_inc,
  input  logic [2*HALF_W-1:0]   count,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic                  wr_step,
  input  logic                  clr_stat,
  input  logic [HALF_W-1:0]     wdata,
  output logic [2*HALF_W-1:0]   cmp,
  output logic [HALF_W-1:0]     step,
  output logic                  stat
);
  localparam int CW = 2 * HALF_W;

  logic hit;
  logic [CW-1:0] next_cmp;

  assign hit      = enable && advance && (count == cmp);
  assign next_cmp = cmp + {{HALF_W{1'b0}}, step};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cmp[HALF_W-1:0]  <= wdata;
      if (wr_hi) cmp[CW-1:HALF_W] <= wdata;
    end else if (hit && auto_inc) begin
      cmp <= next_cmp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       step <= '0;
    else if (wr_step) step <= wdata;
  end

  // a match in the clearing cycle keeps the flag
  always_ff @(posedge clk) begin
    if (!rst_n) stat <= 1'b0;
    else        stat <= (stat && !clr_stat) || hit;
  end

endmodule

// File: rtl/gtick_wack.sv
module gtick_wack #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] pend;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[i]  <= 1'b0;
        flags[i] <= 1'b0;
      end else begin
        pend[i]  <= set[i];
        flags[i] <= (flags[i] && !clr[i]) || pend[i];
      end
    end
  end

endmodule

// File: rtl/gtick_timer.sv
module gtick_timer
  import gtick_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              irq
);
  localparam int CW = 2 * BUS_W;

  ctrl_t             ctrl_q;
  logic              ien_q;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     cmp_q;
  logic [BUS_W-1:0]  step_q;
  logic              stat_q;
  logic [ACK_N-1:0]  ack_g;
  logic [CACK_N-1:0] ack_c;

  logic w_cnt_lo, w_cnt_hi, w_cmp_lo, w_cmp_hi, w_step, w_ctrl;
  logic w_istat, w_ien, w_ack, w_cack, advance;
  logic [ACK_N-1:0]  g_set, g_clr;
  logic [CACK_N-1:0] c_set, c_clr;

  assign w_cnt_lo = wr_en && (addr == A_CNT_LO);
  assign w_cnt_hi = wr_en && (addr == A_CNT_HI);
  assign w_cmp_lo = wr_en && (addr == A_CMP_LO);
  assign w_cmp_hi = wr_en && (addr == A_CMP_HI);
  assign w_step   = wr_en && (addr == A_STEP);
  assign w_ctrl   = wr_en && (addr == A_CTRL);
  assign w_istat  = wr_en && (addr == A_ISTAT);
  assign w_ien    = wr_en && (addr == A_IEN);
  assign w_ack    = wr_en && (addr == A_ACK);
  assign w_cack   = wr_en && (addr == A_CNT_ACK);

  assign advance  = ctrl_q.run && tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      if (w_ctrl) begin
        ctrl_q.run      <= wdata[B_RUN];
        ctrl_q.auto_inc <= wdata[B_AUTO];
        ctrl_q.cmp_en   <= wdata[B_CMP_EN];
      end
      if (w_ien) ien_q <= wdata[0];
    end
  end

  gtick_counter #(.HALF_W(BUS_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .wr_lo   (w_cnt_lo),
    .wr_hi   (w_cnt_hi),
    .wdata   (wdata),
    .count   (cnt_q)
  );

  gtick_compare #(.HALF_W(BUS_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .enable   (ctrl_q.cmp_en),
    .auto_inc (ctrl_q.auto_inc),
    .count    (cnt_q),
    .wr_lo    (w_cmp_lo),
    .wr_hi    (w_cmp_hi),
    .wr_step  (w_step),
    .clr_stat (w_istat && wdata[0]),
    .wdata    (wdata),
    .cmp      (cmp_q),
    .step     (step_q),
    .stat     (stat_q)
  );

  always_comb begin
    g_set = '0;
    g_set[ACK_CMPLO] = w_cmp_lo;
    g_set[ACK_CMPHI] = w_cmp_hi;
    g_set[ACK_STEP]  = w_step;
    g_set[ACK_CTRL]  = w_ctrl;
    g_clr = '0;
    g_clr[ACK_CMPLO] = w_ack && wdata[0];
    g_clr[ACK_CMPHI] = w_ack && wdata[1];
    g_clr[ACK_STEP]  = w_ack && wdata[2];
    g_clr[ACK_CTRL]  = w_ack && wdata[B_ACK_CTRL];
    c_set = {w_cnt_hi, w_cnt_lo};
    c_clr = {w_cack && wdata[1], w_cack && wdata[0]};
  end

  gtick_wack #(.N(ACK_N)) u_ack_g (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (g_set),
    .clr   (g_clr),
    .flags (ack_g)
  );

  gtick_wack #(.N(CACK_N)) u_ack_c (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (c_set),
    .clr   (c_clr),
    .flags (ack_c)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_CNT_LO:  rdata = cnt_q[BUS_W-1:0];
      A_CNT_HI:  rdata = cnt_q[CW-1:BUS_W];
      A_CMP_LO:  rdata = cmp_q[BUS_W-1:0];
      A_CMP_HI:  rdata = cmp_q[CW-1:BUS_W];
      A_STEP:    rdata = step_q;
      A_CTRL: begin
        rdata[B_RUN]    = ctrl_q.run;
        rdata[B_AUTO]   = ctrl_q.auto_inc;
        rdata[B_CMP_EN] = ctrl_q.cmp_en;
      end
      A_ISTAT:   rdata[0] = stat_q;
      A_IEN:     rdata[0] = ien_q;
      A_ACK: begin
        rdata[0]          = ack_g[ACK_CMPLO];
        rdata[1]          = ack_g[ACK_CMPHI];
        rdata[2]          = ack_g[ACK_STEP];
        rdata[B_ACK_CTRL] = ack_g[ACK_CTRL];
      end
      A_CNT_ACK: rdata[CACK_N-1:0] = ack_c;
      default:   rdata = '0;
    endcase
  end

  assign irq = stat_q && ien_q;

endmodule

// File: rtl/gtick_timer_chk.sv
module gtick_timer_chk
  import gtick_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic                 wdata0,
  input logic                 run,
  input logic                 cmp_en,
  input logic                 auto_inc,
  input logic [2*BUS_W-1:0]   cnt,
  input logic [2*BUS_W-1:0]   cmp,
  input logic [BUS_W-1:0]     step,
  input logic                 stat,
  input logic                 ien,
  input logic                 irq,
  input logic                 ack_ctrl
);
  localparam int CW = 2 * BUS_W;

  logic cnt_wr, cmp_wr, stat_clr, hit;
  assign cnt_wr   = wr_en && (addr == A_CNT_LO || addr == A_CNT_HI);
  assign cmp_wr   = wr_en && (addr == A_CMP_LO || addr == A_CMP_HI);
  assign stat_clr = wr_en && (addr == A_ISTAT) && wdata0;
  assign hit      = run && tick && cmp_en && (cnt == cmp);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !cnt_wr) |=> (cnt == $past(cnt) + CW'(1)));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run && tick) && !cnt_wr) |=> $stable(cnt));

  assert_match_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> stat);

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat && !hit) |=> !stat);

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat && !stat_clr) |=> stat);

  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat && ien));

  assert_auto_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && auto_inc && !cmp_wr) |=> (cmp == $past(cmp) + {{BUS_W{1'b0}}, $past(step)}));

  assert_ctrl_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL) |=> ##1 ack_ctrl);

endmodule

bind gtick_timer gtick_timer_chk #(.BUS_W(BUS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata0   (wdata[0]),
  .run      (ctrl_q.run),
  .cmp_en   (ctrl_q.cmp_en),
  .auto_inc (ctrl_q.auto_inc),
  .cnt      (cnt_q),
  .cmp      (cmp_q),
  .step     (step_q),
  .stat     (stat_q),
  .ien      (ien_q),
  .irq      (irq),
  .ack_ctrl (ack_g[3])
);

// File: tb/gtick_timer_test.sv
module gtick_timer_test;

  localparam time CLK_P = 8ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gtick_timer uut (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .addr  (addr),
    .wr_en (wr_en),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  // scoreboard queues: kind 0 = register read at addr, kind 1 = irq pin
  logic [31:0] exp_q[$];
  bit          kind_q[$];
  string       tag_q[$];
  event        mon_ev;

  initial begin
    forever begin
      @(mon_ev);
      begin
        logic [31:0] e, a;
        bit          k;
        string       t;
        e = exp_q.pop_front();
        k = kind_q.pop_front();
        t = tag_q.pop_front();
        a = k ? {31'b0, irq} : rdata;
        n_checks++;
        if (a !== e) begin
          n_fails++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", t, a, e);
        end
      end
    end
  end

  task automatic exp_reg(input logic [11:0] a, input logic [31:0] v, input string t);
    addr = a;
    #1;
    exp_q.push_back(v); kind_q.push_back(1'b0); tag_q.push_back(t);
    -> mon_ev;
    #1;
  endtask

  task automatic exp_irq(input bit v, input string t);
    #1;
    exp_q.push_back({31'b0, v}); kind_q.push_back(1'b1); tag_q.push_back(t);
    -> mon_ev;
    #1;
  endtask

  // entered at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset values, R10 unmapped
    exp_reg(12'h240, 32'h0, "R9 ctrl");
    exp_reg(12'h100, 32'h0, "R9 count");
    exp_reg(12'h244, 32'h0, "R9 status");
    exp_reg(12'h24C, 32'h0, "R9 ack");
    exp_irq(1'b0, "R9 irq");
    exp_reg(12'h300, 32'h0, "R10 unmapped");

    // R1 / R8 counter writes and acknowledge
    wr(12'h100, 32'hFFFF_FFFE);
    exp_reg(12'h110, 32'h0, "R8 not yet");
    @(negedge clk);
    exp_reg(12'h110, 32'h1, "R8 low ack");
    wr(12'h104, 32'hFFFF_FFFF);
    @(negedge clk);
    exp_reg(12'h110, 32'h3, "R8 both ack");
    wr(12'h110, 32'h1);
    exp_reg(12'h110, 32'h2, "R8 clear low");
    exp_reg(12'h100, 32'hFFFF_FFFE, "R1 low");
    exp_reg(12'h104, 32'hFFFF_FFFF, "R1 high");

    // R2 hold while stopped, then wrap
    ticks(3);
    exp_reg(12'h100, 32'hFFFF_FFFE, "R2 hold");
    wr(12'h240, 32'h100);
    ticks(1);
    exp_reg(12'h100, 32'hFFFF_FFFF, "R2 step");
    ticks(1);
    exp_reg(12'h100, 32'h0, "R2 wrap low");
    exp_reg(12'h104, 32'h0, "R2 wrap high");

    // R3 / R5 one-shot match
    wr(12'h200, 32'd5);
    wr(12'h204, 32'd0);
    wr(12'h240, 32'h101);
    ticks(5);
    exp_reg(12'h100, 32'd5, "R3 count");
    exp_reg(12'h244, 32'h0, "R3 before match");
    ticks(1);
    exp_reg(12'h244, 32'h1, "R3 match");
    exp_irq(1'b0, "R5 gated off");
    wr(12'h248, 32'h1);
    exp_irq(1'b1, "R5 enabled");
    wr(12'h244, 32'h1);
    exp_reg(12'h244, 32'h0, "R4 clear");
    exp_irq(1'b0, "R5 after clear");

    // R6 auto-increment
    wr(12'h208, 32'd4);
    wr(12'h200, 32'd10);
    wr(12'h240, 32'h103);
    ticks(5);
    exp_reg(12'h244, 32'h1, "R6 first match");
    exp_reg(12'h200, 32'd14, "R6 advanced");
    wr(12'h244, 32'h1);
    ticks(3);
    exp_reg(12'h244, 32'h0, "R6 between");
    ticks(1);
    exp_reg(12'h244, 32'h1, "R6 second match");
    exp_reg(12'h200, 32'd18, "R6 advanced again");

    // R4 collision: clear lands on the match edge (count 15 -> edge 4 leaves 18)
    tick = 1'b1;
    repeat (3) @(negedge clk);
    wr(12'h244, 32'h1);
    tick = 1'b0;
    exp_reg(12'h244, 32'h1, "R4 set wins");
    exp_reg(12'h100, 32'd19, "R2 count 19");
    exp_reg(12'h200, 32'd22, "R6 compare 22");

    // R6 collision: software write lands on the match edge
    tick = 1'b1;
    repeat (3) @(negedge clk);
    wr(12'h200, 32'd100);
    tick = 1'b0;
    exp_reg(12'h200, 32'd100, "R6 write wins");
    exp_reg(12'h100, 32'd23, "R2 count 23");

    // R3 comparator disabled
    wr(12'h240, 32'h100);
    wr(12'h244, 32'h1);
    exp_reg(12'h244, 32'h0, "R4 cleared");
    ticks(80);
    exp_reg(12'h100, 32'd103, "R2 count 103");
    exp_reg(12'h244, 32'h0, "R3 disabled no match");
    exp_irq(1'b0, "R5 no irq");

    // R7 global acknowledge
    wr(12'h24C, 32'h0001_0007);
    exp_reg(12'h24C, 32'h0, "R7 cleared");
    wr(12'h208, 32'd7);
    exp_reg(12'h24C, 32'h0, "R7 delay");
    @(negedge clk);
    exp_reg(12'h24C, 32'h4, "R7 step ack");
    wr(12'h240, 32'h100);
    @(negedge clk);
    exp_reg(12'h24C, 32'h0001_0004, "R7 ctrl ack");
    wr(12'h204, 32'h0);
    @(negedge clk);
    exp_reg(12'h24C, 32'h0001_0006, "R7 cmp high ack");
    wr(12'h24C, 32'h4);
    exp_reg(12'h24C, 32'h0001_0002, "R7 partial clear");

    // R1 half independence
    wr(12'h104, 32'h12);
    exp_reg(12'h104, 32'h12, "R1 high write");
    exp_reg(12'h100, 32'd103, "R1 low kept");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule